// File: doc/BRIEF.md
# BCD calendar clock register file

This block models a calendar clock that keeps the time of day and the date as thirteen 4-bit registers. Each register holds one BCD digit or a small field: seconds, minutes, hours, weekday, day of month, month and two-digit year. A host reaches the registers over a 4-bit data bus. It supplies a 4-bit register address, a read strobe and a write strobe. A separate one-second `tick` input advances the time. Carries ripple in BCD from seconds up through the year.

Two configuration flags share registers with time digits. The top bits of the hours-tens register select 24-hour or 12-hour counting and hold the PM flag. A spare bit in the day-tens register selects a 29-day February. Any write to either seconds register zeroes the seconds instead of storing the data. This lets the host start the time at an exact second boundary.

Reads are combinational. `rdata` shows the addressed register while `rd_en` is high and is zero otherwise. A write takes effect on the next rising clock edge.

Top module: `bcd_calendar_regs`

## Requirements
- R1: After a synchronous active-low reset, the time reads 00:00:00 in 24-hour mode with PM clear, weekday 0, day 01, month 01, year 00 and leap flag clear. Register 5 reads 4'b1000 and registers 7 and 9 read 1. All other registers read 0.
- R2: While `rd_en` is low, `rdata` is 0. While `rd_en` is high, `rdata` shows the addressed register in the same cycle.
- R3: A write to address 0 (seconds units) or address 1 (seconds tens) sets both seconds digits to 0, whatever the write data.
- R4: Bits with no storage read as 0 and ignore written data. Address 1 keeps 3 bits and address 3 keeps 3 bits. Address 5 keeps bit 3 (24-hour mode), bit 2 (PM) and bits 1:0 (hours tens). Address 6 keeps 3 bits. Address 8 keeps bit 2 (leap February) and bits 1:0 (day tens). Address 10 keeps bit 0. The other addresses up to 12 keep all 4 bits.
- R5: Each clock cycle with `tick` high and no write advances the seconds by one in BCD. Seconds 59 wraps to 00 and carries into the minutes.
- R6: With neither `tick` nor `wr_en` high, no register changes.
- R7: When `wr_en` and `tick` are high in the same cycle, the write is applied and that tick is dropped.
- R8: Minutes wrap from 59 to 00 and carry into the hours. In 24-hour mode, hours count 00 to 23. Hour 23 wraps to 00 and carries into the date.
- R9: In 12-hour mode, hours count 01 to 12. Hour 11 goes to 12 and toggles PM. Hour 12 goes to 01. The date advances only when 11 PM passes to 12 AM.
- R10: On each date carry, the weekday advances by one and wraps from 6 to 0.
- R11: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In month 02 it wraps after day 29 with the leap flag set and after day 28 with it clear. The wrap carries into the month.
- R12: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R13: Addresses 13, 14 and 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 4 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 4 | Read data, 0 when `rd_en` is low |

## Verification
The hardest states to reach from the ports are the deep carries. Examples are the last second of a 28-day February, the last second of the year, and 11:59:59 PM in 12-hour mode. Ticking from reset would take millions of cycles. Instead the stimulus writes the target hour, minute, date and flags directly. It then uses the write-clears-seconds rule to land on second 00 and applies 60 ticks to cross exactly one minute boundary. A write and a tick in the same cycle are also driven on purpose, to show which one wins.

// File: rtl/cal_pkg.sv
// Package: shared constants, state layout and digit helpers for the
// BCD calendar clock. Assumes 4-bit registers and the 13-entry map below.
package cal_pkg;

    localparam int CAL_AW    = 4;
    localparam int CAL_DW    = 4;
    localparam int CAL_NREGS = 13;

    // Address map; the order is decoded by host software, so it is fixed.
    localparam logic [CAL_AW-1:0] A_SEC1  = 4'd0;
    localparam logic [CAL_AW-1:0] A_SEC10 = 4'd1;
    localparam logic [CAL_AW-1:0] A_MIN1  = 4'd2;
    localparam logic [CAL_AW-1:0] A_MIN10 = 4'd3;
    localparam logic [CAL_AW-1:0] A_HR1   = 4'd4;
    localparam logic [CAL_AW-1:0] A_HR10  = 4'd5;
    localparam logic [CAL_AW-1:0] A_WDAY  = 4'd6;
    localparam logic [CAL_AW-1:0] A_DAY1  = 4'd7;
    localparam logic [CAL_AW-1:0] A_DAY10 = 4'd8;
    localparam logic [CAL_AW-1:0] A_MON1  = 4'd9;
    localparam logic [CAL_AW-1:0] A_MON10 = 4'd10;
    localparam logic [CAL_AW-1:0] A_YR1   = 4'd11;
    localparam logic [CAL_AW-1:0] A_YR10  = 4'd12;

    typedef struct packed {
        logic [3:0] yr_t;
        logic [3:0] yr_u;
        logic       mon_t;
        logic [3:0] mon_u;
        logic       leap;
        logic [1:0] day_t;
        logic [3:0] day_u;
        logic [2:0] wday;
        logic       mode24;
        logic       pm;
        logic [1:0] hr_t;
        logic [3:0] hr_u;
        logic [2:0] min_t;
        logic [3:0] min_u;
        logic [2:0] sec_t;
        logic [3:0] sec_u;
    } cal_state_t;

    localparam cal_state_t CAL_RESET = '{
        yr_t: 4'd0, yr_u: 4'd0, mon_t: 1'b0, mon_u: 4'd1, leap: 1'b0,
        day_t: 2'd0, day_u: 4'd1, wday: 3'd0, mode24: 1'b1, pm: 1'b0,
        hr_t: 2'd0, hr_u: 4'd0, min_t: 3'd0, min_u: 4'd0,
        sec_t: 3'd0, sec_u: 4'd0
    };

    // Binary value of a tens/units digit pair.
    function automatic logic [7:0] bcd2bin(input logic [3:0] tens,
                                           input logic [3:0] ones);
        return ({4'd0, tens} * 8'd10) + {4'd0, ones};
    endfunction

    // True when the units digit rolls over into the tens digit.
    function automatic logic unit_roll(input logic [3:0] ones);
        return ones >= 4'd9;
    endfunction

    // Next units digit of a plain BCD increment.
    function automatic logic [3:0] unit_next(input logic [3:0] ones);
        return unit_roll(ones) ? 4'd0 : ones + 4'd1;
    endfunction

    // Length of a month given its binary number and the leap flag.
    function automatic logic [7:0] month_len(input logic [7:0] mon,
                                             input logic leap);
        case (mon)
            8'd2:                       return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
            default:                    return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_advance.sv
// Module: cal_advance
// Computes the full one-second successor of the calendar state in a single
// combinational pass, carrying seconds through the year. Assumes the caller
// decides whether the result is taken; out-of-range digits wrap to the
// lowest legal value at the next carry.
module cal_advance
    import cal_pkg::*;
(
    input  cal_state_t cur,
    output cal_state_t nxt
);

    logic       c_min, c_hr, c_day, c_mon, c_yr;
    logic [7:0] sec_v, min_v, hr_v, day_v, mon_v, yr_v;

    // Binary values of each digit pair, used for the wrap comparisons.
    always_comb begin
        sec_v = bcd2bin({1'b0, cur.sec_t}, cur.sec_u);
        min_v = bcd2bin({1'b0, cur.min_t}, cur.min_u);
        hr_v  = bcd2bin({2'b0, cur.hr_t}, cur.hr_u);
        day_v = bcd2bin({2'b0, cur.day_t}, cur.day_u);
        mon_v = bcd2bin({3'b0, cur.mon_t}, cur.mon_u);
        yr_v  = bcd2bin(cur.yr_t, cur.yr_u);
    end

    // Ripple the tick through every field, one carry feeding the next.
    always_comb begin
        nxt   = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (sec_v >= 8'd59) begin
            nxt.sec_t = 3'd0;
            nxt.sec_u = 4'd0;
            c_min     = 1'b1;
        end else begin
            nxt.sec_u = unit_next(cur.sec_u);
            nxt.sec_t = unit_roll(cur.sec_u) ? cur.sec_t + 3'd1 : cur.sec_t;
        end

        if (c_min) begin
            if (min_v >= 8'd59) begin
                nxt.min_t = 3'd0;
                nxt.min_u = 4'd0;
                c_hr      = 1'b1;
            end else begin
                nxt.min_u = unit_next(cur.min_u);
                nxt.min_t = unit_roll(cur.min_u) ? cur.min_t + 3'd1 : cur.min_t;
            end
        end

        if (c_hr) begin
            if (cur.mode24) begin
                if (hr_v >= 8'd23) begin
                    nxt.hr_t = 2'd0;
                    nxt.hr_u = 4'd0;
                    c_day    = 1'b1;
                end else begin
                    nxt.hr_u = unit_next(cur.hr_u);
                    nxt.hr_t = unit_roll(cur.hr_u) ? cur.hr_t + 2'd1 : cur.hr_t;
                end
            end else begin
                if (hr_v == 8'd11) begin
                    nxt.hr_t = 2'd1;
                    nxt.hr_u = 4'd2;
                    nxt.pm   = ~cur.pm;
                    c_day    = cur.pm;
                end else if (hr_v >= 8'd12) begin
                    nxt.hr_t = 2'd0;
                    nxt.hr_u = 4'd1;
                end else begin
                    nxt.hr_u = unit_next(cur.hr_u);
                    nxt.hr_t = unit_roll(cur.hr_u) ? cur.hr_t + 2'd1 : cur.hr_t;
                end
            end
        end

        if (c_day) begin
            nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
            if (day_v >= month_len(mon_v, cur.leap)) begin
                nxt.day_t = 2'd0;
                nxt.day_u = 4'd1;
                c_mon     = 1'b1;
            end else begin
                nxt.day_u = unit_next(cur.day_u);
                nxt.day_t = unit_roll(cur.day_u) ? cur.day_t + 2'd1 : cur.day_t;
            end
        end

        if (c_mon) begin
            if (mon_v >= 8'd12) begin
                nxt.mon_t = 1'b0;
                nxt.mon_u = 4'd1;
                c_yr      = 1'b1;
            end else begin
                nxt.mon_u = unit_next(cur.mon_u);
                nxt.mon_t = unit_roll(cur.mon_u) ? 1'b1 : cur.mon_t;
            end
        end

        if (c_yr) begin
            if (yr_v >= 8'd99) begin
                nxt.yr_t = 4'd0;
                nxt.yr_u = 4'd0;
            end else begin
                nxt.yr_u = unit_next(cur.yr_u);
                nxt.yr_t = unit_roll(cur.yr_u) ? cur.yr_t + 4'd1 : cur.yr_t;
            end
        end
    end

endmodule

// File: rtl/cal_reg_bank.sv
// Module: cal_reg_bank
// Holds the calendar state. A host write has priority over a tick in the
// same cycle; writes to either seconds address zero the seconds. Assumes
// nxt is the one-tick successor of st.
module cal_reg_bank
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CAL_AW-1:0] addr,
    input  logic [CAL_DW-1:0] wdata,
    input  cal_state_t        nxt,
    output cal_state_t        st
);

    // State update: reset, then host write, then tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= CAL_RESET;
        end else if (wr_en) begin
            case (addr)
                A_SEC1, A_SEC10: begin
                    st.sec_u <= 4'd0;
                    st.sec_t <= 3'd0;
                end
                A_MIN1:  st.min_u <= wdata;
                A_MIN10: st.min_t <= wdata[2:0];
                A_HR1:   st.hr_u  <= wdata;
                A_HR10: begin
                    st.mode24 <= wdata[3];
                    st.pm     <= wdata[2];
                    st.hr_t   <= wdata[1:0];
                end
                A_WDAY:  st.wday  <= wdata[2:0];
                A_DAY1:  st.day_u <= wdata;
                A_DAY10: begin
                    st.leap  <= wdata[2];
                    st.day_t <= wdata[1:0];
                end
                A_MON1:  st.mon_u <= wdata;
                A_MON10: st.mon_t <= wdata[0];
                A_YR1:   st.yr_u  <= wdata;
                A_YR10:  st.yr_t  <= wdata;
                default: ;
            endcase
        end else if (tick) begin
            st <= nxt;
        end
    end

endmodule

// File: rtl/cal_read_mux.sv
// Module: cal_read_mux
// Combinational read port: places the addressed field on the 4-bit bus,
// zero-filling bits with no storage. Assumes the bus is zero when not read.
module cal_read_mux
    import cal_pkg::*;
(
    input  logic              rd_en,
    input  logic [CAL_AW-1:0] addr,
    input  cal_state_t        st,
    output logic [CAL_DW-1:0] rdata
);

    logic [CAL_DW-1:0] sel;

    // Field select by address.
    always_comb begin
        case (addr)
            A_SEC1:  sel = st.sec_u;
            A_SEC10: sel = {1'b0, st.sec_t};
            A_MIN1:  sel = st.min_u;
            A_MIN10: sel = {1'b0, st.min_t};
            A_HR1:   sel = st.hr_u;
            A_HR10:  sel = {st.mode24, st.pm, st.hr_t};
            A_WDAY:  sel = {1'b0, st.wday};
            A_DAY1:  sel = st.day_u;
            A_DAY10: sel = {1'b0, st.leap, st.day_t};
            A_MON1:  sel = st.mon_u;
            A_MON10: sel = {3'b000, st.mon_t};
            A_YR1:   sel = st.yr_u;
            A_YR10:  sel = st.yr_t;
            default: sel = '0;
        endcase
    end

    // Bus gating by the read strobe.
    always_comb begin
        rdata = rd_en ? sel : '0;
    end

endmodule

// File: rtl/bcd_calendar_regs.sv
// Module: bcd_calendar_regs (top)
// BCD calendar clock register file: 13 nibble registers, host read/write
// port and a one-second tick input. Assumes tick is a one-cycle pulse in
// the clk domain.
module bcd_calendar_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CAL_AW-1:0] addr,
    input  logic [CAL_DW-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [CAL_DW-1:0] rdata
);

    cal_state_t st_q;
    cal_state_t st_nxt;

    cal_reg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .nxt   (st_nxt),
        .st    (st_q)
    );

    cal_advance u_adv (
        .cur (st_q),
        .nxt (st_nxt)
    );

    cal_read_mux u_rd (
        .rd_en (rd_en),
        .addr  (addr),
        .st    (st_q),
        .rdata (rdata)
    );

endmodule

// File: rtl/cal_checker.sv
// Module: cal_checker
// Temporal properties of the calendar register file, bound to the top.
// Assumes it observes the top's stored state st_q.
module cal_checker
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rd_en,
    input logic              wr_en,
    input logic [CAL_AW-1:0] addr,
    input logic [CAL_DW-1:0] wdata,
    input logic [CAL_DW-1:0] rdata,
    input cal_state_t        st
);

    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    a_r3_sec_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr <= A_SEC10) |=> (st.sec_u == 4'd0 && st.sec_t == 3'd0));

    a_r4_month_tens_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_MON10) |-> rdata[3:1] == 3'b000);

    a_r5_tick_moves_seconds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> st.sec_u != $past(st.sec_u));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(st));

    a_r7_write_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tick && addr == A_MIN1) |=> st.min_u == $past(wdata));

    a_r13_high_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= 4'd13) |-> rdata == '0);

endmodule

bind bcd_calendar_regs cal_checker u_cal_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .st    (st_q)
);

// File: tb/tb_bcd_calendar_regs.sv
`timescale 1ns/1ps
module tb_bcd_calendar_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [3:0] wdata = 4'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bcd_calendar_regs dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic       m24;
        logic       pm_i;
        logic [7:0] hr_i;
        logic [7:0] day_i;
        logic [7:0] mon_i;
        logic [7:0] yr_i;
        logic       leap;
        logic [3:0] wd_i;
        logic       pm_o;
        logic [7:0] hr_o;
        logic [7:0] day_o;
        logic [7:0] mon_o;
        logic [7:0] yr_o;
        logic [3:0] wd_o;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    // Start at hh:59:00, apply 60 ticks, expect the state one minute later.
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,8'h10,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b0,8'h11,8'h15,8'h06,8'h24,4'd2, 4'd8},  // R8 plain hour
        '{1'b1,1'b0,8'h09,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b0,8'h10,8'h15,8'h06,8'h24,4'd2, 4'd8},  // R8 units roll
        '{1'b1,1'b0,8'h23,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b0,8'h00,8'h16,8'h06,8'h24,4'd3, 4'd8},  // R8 midnight
        '{1'b1,1'b0,8'h23,8'h15,8'h06,8'h24,1'b0,4'd6, 1'b0,8'h00,8'h16,8'h06,8'h24,4'd0, 4'd10}, // R10 weekday wrap
        '{1'b1,1'b0,8'h23,8'h30,8'h04,8'h24,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h05,8'h24,4'd2, 4'd11}, // R11 30-day
        '{1'b1,1'b0,8'h23,8'h30,8'h05,8'h24,1'b0,4'd1, 1'b0,8'h00,8'h31,8'h05,8'h24,4'd2, 4'd11}, // R11 31-day
        '{1'b1,1'b0,8'h23,8'h31,8'h01,8'h24,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h02,8'h24,4'd2, 4'd11}, // R11
        '{1'b1,1'b0,8'h23,8'h28,8'h02,8'h23,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h03,8'h23,4'd2, 4'd11}, // R11 Feb 28
        '{1'b1,1'b0,8'h23,8'h28,8'h02,8'h24,1'b1,4'd1, 1'b0,8'h00,8'h29,8'h02,8'h24,4'd2, 4'd11}, // R11 leap
        '{1'b1,1'b0,8'h23,8'h29,8'h02,8'h24,1'b1,4'd1, 1'b0,8'h00,8'h01,8'h03,8'h24,4'd2, 4'd11}, // R11 leap end
        '{1'b1,1'b0,8'h23,8'h30,8'h11,8'h24,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h12,8'h24,4'd2, 4'd11}, // R11 Nov
        '{1'b1,1'b0,8'h23,8'h30,8'h09,8'h24,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h10,8'h24,4'd2, 4'd11}, // R11 Sep, month tens
        '{1'b1,1'b0,8'h23,8'h31,8'h12,8'h23,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h01,8'h24,4'd2, 4'd12}, // R12 new year
        '{1'b1,1'b0,8'h23,8'h31,8'h12,8'h99,1'b0,4'd1, 1'b0,8'h00,8'h01,8'h01,8'h00,4'd2, 4'd12}, // R12 year wrap
        '{1'b0,1'b0,8'h11,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b1,8'h12,8'h15,8'h06,8'h24,4'd2, 4'd9},  // R9 noon
        '{1'b0,1'b1,8'h12,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b1,8'h01,8'h15,8'h06,8'h24,4'd2, 4'd9},  // R9 12 to 1
        '{1'b0,1'b1,8'h11,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b0,8'h12,8'h16,8'h06,8'h24,4'd3, 4'd9},  // R9 midnight
        '{1'b0,1'b0,8'h09,8'h15,8'h06,8'h24,1'b0,4'd2, 1'b0,8'h10,8'h15,8'h06,8'h24,4'd2, 4'd9}   // R9 units roll
    };

    task automatic check(input string req, input logic [51:0] act,
                         input logic [51:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic read_all(output logic [51:0] img);
        logic [3:0] n;
        img = '0;
        for (int a = 0; a < 13; a++) begin
            rd(4'(a), n);
            img[a*4 +: 4] = n;
        end
    endtask

    task automatic set_time(input vec_t v);
        wr(4'd2, 4'h9);
        wr(4'd3, 4'h5);
        wr(4'd4, v.hr_i[3:0]);
        wr(4'd5, {v.m24, v.pm_i, v.hr_i[5:4]});
        wr(4'd6, v.wd_i);
        wr(4'd7, v.day_i[3:0]);
        wr(4'd8, {1'b0, v.leap, v.day_i[5:4]});
        wr(4'd9, v.mon_i[3:0]);
        wr(4'd10, {3'b000, v.mon_i[4]});
        wr(4'd11, v.yr_i[3:0]);
        wr(4'd12, v.yr_i[7:4]);
        wr(4'd0, 4'hA);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [51:0] img, img2, exp;
        logic [3:0]  n0, n1, n2, n3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        read_all(img);
        check("R1 reset image", img, 52'h0001010800000);

        // R2 bus idle without read strobe
        @(negedge clk);
        addr = 4'd5; rd_en = 1'b0;
        #1 check("R2 idle bus", {48'd0, rdata}, 52'd0);

        // R5 fifteen ticks from zero
        wr(4'd0, 4'h0);
        ticks(15);
        rd(4'd1, n1); rd(4'd0, n0);
        check("R5 seconds count", {44'd0, n1, n0}, 52'h15);

        // R3 write to tens address clears seconds
        wr(4'd1, 4'hF);
        rd(4'd1, n1); rd(4'd0, n0);
        check("R3 clear via addr 1", {44'd0, n1, n0}, 52'h0);
        ticks(7);
        wr(4'd0, 4'h9);
        rd(4'd1, n1); rd(4'd0, n0);
        check("R3 clear via addr 0", {44'd0, n1, n0}, 52'h0);

        // R7 write and tick together
        @(negedge clk);
        addr = 4'd2; wdata = 4'd3; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(4'd2, n2); rd(4'd0, n0);
        check("R7 write wins", {44'd0, n2, n0}, 52'h30);

        // R4 unused bits masked
        wr(4'd10, 4'hF); wr(4'd8, 4'hF); wr(4'd6, 4'hF); wr(4'd3, 4'hF);
        rd(4'd10, n0); rd(4'd8, n1); rd(4'd6, n2); rd(4'd3, n3);
        check("R4 masked bits", {36'd0, n0, n1, n2, n3}, 52'h1777);
        wr(4'd5, 4'hF); wr(4'd1, 4'hF);
        rd(4'd5, n0); rd(4'd1, n1);
        check("R4 hour flags kept", {44'd0, n0, n1}, 52'hF0);

        // R6 idle cycles change nothing
        read_all(img);
        repeat (10) @(negedge clk);
        read_all(img2);
        check("R6 hold", img2, img);

        // R13 high addresses
        wr(4'd13, 4'hF); wr(4'd14, 4'hF); wr(4'd15, 4'hF);
        read_all(img2);
        check("R13 writes ignored", img2, img);
        rd(4'd13, n0); rd(4'd14, n1); rd(4'd15, n2);
        check("R13 reads zero", {40'd0, n0, n1, n2}, 52'h0);

        // Table walk: R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            set_time(VECS[i]);
            ticks(60);
            read_all(img);
            exp = {VECS[i].yr_o[7:4], VECS[i].yr_o[3:0],
                   3'b000, VECS[i].mon_o[4], VECS[i].mon_o[3:0],
                   1'b0, VECS[i].leap, VECS[i].day_o[5:4], VECS[i].day_o[3:0],
                   1'b0, VECS[i].wd_o[2:0],
                   VECS[i].m24, VECS[i].pm_o, VECS[i].hr_o[5:4], VECS[i].hr_o[3:0],
                   16'h0000};
            check($sformatf("R%0d vector %0d", VECS[i].req, i), img, exp);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule